// File: doc/BRIEF.md
# Per-Block Write Protection Controller

This block keeps a three-valued protection state for every erase block of a flash array and changes those states on command. Software, or a higher-level sequencer, first loads a first-block and a last-block register, then issues a command opcode. The controller walks the inclusive block range one block per clock. It writes each new state into the per-block table and into a protection status register, and it ends with a one-cycle done pulse and a sticky interrupt flag.

Blocks move between three states: open (writable), locked, and tight. A tight block can never leave that state until reset. Lock and unlock walks stop as soon as they reach a tight block. A tighten walk passes over open blocks and leaves them open. A separate query port returns the state of any block, and a writable flag that program and erase logic can use for gating. Commands arrive on a valid/ready pair. `cmd_ready` is low for the whole of a walk, and a requester must hold `cmd_valid` and `cmd_op` steady until it sees ready.

Top module: `wp_guard`

## Requirements
- R1: After reset every block reads locked, and the protection status reads 3'b010. The state encoding is 3'b001 tight, 3'b010 locked and 3'b100 open. After reset, busy, done, cmd_err and irq are all 0, and both address registers are 0.
- R2: A write with reg_sel=0 stores reg_wdata[IDX_W-1:0] into the first-block register and the same value into the last-block register. A write with reg_sel=1 stores reg_wdata[IDX_W-1:0] into the last-block register only.
- R3: Register writes are ignored while busy. cmd_ready is the inverse of busy.
- R4: Opcode 8'h23 sets each block from first to last to open, and opcode 8'h2A sets each of them to locked. The walk visits one block per clock. done pulses for one cycle, n cycles after the accepting edge, where n is the number of blocks visited, and busy falls at the same edge.
- R5: Opcode 8'h27 opens every block from 0 to NUM_BLOCKS-1, whatever the address registers hold.
- R6: A lock or unlock walk that reaches a tight block ends at that block and leaves it unchanged. That block counts as visited.
- R7: Opcode 8'h2C makes each non-open block in the range tight. It skips open blocks and carries on with the walk.
- R8: Each block that is written puts its new state into wp_status. wp_status is always one-hot.
- R9: A walk that reaches a block index of NUM_BLOCKS or more ends there, visits nothing further and sets cmd_err. The address mask is the full index width, so with NUM_BLOCKS=12 the indices 12 to 15 can be loaded. A range whose first block is above its last block ends after one cycle with no change and no error.
- R10: Every command sets irq as it ends. Accepting a command clears irq and cmd_err. An opcode outside the four above ends after one cycle with cmd_err set and no state change.
- R11: q_state returns the state of block q_blk, and q_writable is 1 exactly when that block is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (cold reset) |
| reg_we | input | 1 | Address register write strobe |
| reg_sel | input | 1 | 0 = first-block register (copies into last), 1 = last-block register |
| reg_wdata | input | DATA_W | Write data; the low IDX_W bits are kept |
| first_blk | output | IDX_W | First-block register |
| last_blk | output | IDX_W | Last-block register |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 8 | Command opcode |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| cmd_err | output | 1 | Range or opcode error of the last command |
| irq | output | 1 | Sticky end-of-command flag |
| wp_status | output | 3 | Last state written to a block |
| q_blk | input | IDX_W | Query block index |
| q_state | output | 3 | State of the queried block |
| q_writable | output | 1 | Queried block is open |

## Verification
A command accepted at edge k keeps busy high until edge k+n, where n counts every block visited, including a terminating tight block, an out-of-range index or an empty range. done, irq, cmd_err and the last wp_status value appear just after edge k+n. The bench counts falling edges from acceptance until done is seen and compares that count with n, worked out by hand for each scenario. It then reads every affected block through the combinational query port, half a cycle away from any active edge. Register writes aimed at a running walk are presented during a busy cycle and read back after the walk ends.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam logic [2:0] WP_TIGHT  = 3'b001;
  localparam logic [2:0] WP_LOCKED = 3'b010;
  localparam logic [2:0] WP_OPEN   = 3'b100;

  localparam logic [7:0] OP_UNLOCK     = 8'h23;
  localparam logic [7:0] OP_UNLOCK_ALL = 8'h27;
  localparam logic [7:0] OP_LOCK       = 8'h2A;
  localparam logic [7:0] OP_TIGHTEN    = 8'h2C;

  typedef enum logic [1:0] {K_UNLOCK, K_LOCK, K_TIGHTEN, K_BAD} walk_kind_e;
endpackage

// File: rtl/wp_lock_array.sv
module wp_lock_array #(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [2:0]       wr_state,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [2:0]       rd_state,
  input  logic [IDX_W-1:0] q_idx,
  output logic [2:0]       q_state
);
  import wp_pkg::*;

  logic [2:0] st_q [NUM_BLOCKS];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  st_q[g] <= WP_LOCKED;
      else if (wr_en && (wr_idx == IDX_W'(g)))     st_q[g] <= wr_state;
    end
  end

  // Indices past the table read as all-zero (no valid state).
  always_comb begin
    rd_state = '0;
    q_state  = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_state = st_q[i];
      if (q_idx  == IDX_W'(i)) q_state  = st_q[i];
    end
  end
endmodule

// File: rtl/wp_range_walker.sv
module wp_range_walker #(
  parameter int NUM_BLOCKS = 12,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_op,
  output logic             cmd_ready,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [2:0]       cur_state,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wr_en,
  output logic [2:0]       wr_state,
  output logic             busy,
  output logic             done,
  output logic             cmd_err,
  output logic             irq,
  output logic [2:0]       wp_status
);
  import wp_pkg::*;

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_BLOCKS - 1);

  logic             busy_q, done_q, err_q, irq_q;
  walk_kind_e       kind_q, kind_d;
  logic [IDX_W-1:0] cur_q, last_q;
  logic [2:0]       wp_q;
  logic             accept, finish, fail, in_range, blk_ok, at_last;

  assign accept   = cmd_valid && !busy_q;
  assign in_range = (cur_q <= last_q);
  assign blk_ok   = (32'(cur_q) < NUM_BLOCKS);
  assign at_last  = (cur_q == last_q);

  always_comb begin
    unique case (cmd_op)
      OP_UNLOCK, OP_UNLOCK_ALL: kind_d = K_UNLOCK;
      OP_LOCK:                  kind_d = K_LOCK;
      OP_TIGHTEN:               kind_d = K_TIGHTEN;
      default:                  kind_d = K_BAD;
    endcase
  end

  // One visit per busy cycle: decide write, termination and error.
  always_comb begin
    wr_en    = 1'b0;
    wr_state = WP_LOCKED;
    finish   = 1'b0;
    fail     = 1'b0;
    if (busy_q) begin
      if (kind_q == K_BAD) begin
        finish = 1'b1;
        fail   = 1'b1;
      end else if (!in_range) begin
        finish = 1'b1;
      end else if (!blk_ok) begin
        finish = 1'b1;
        fail   = 1'b1;
      end else if (kind_q == K_TIGHTEN) begin
        if (cur_state != WP_OPEN) begin
          wr_en    = 1'b1;
          wr_state = WP_TIGHT;
        end
        finish = at_last;
      end else if (cur_state == WP_TIGHT) begin
        finish = 1'b1;
      end else begin
        wr_en    = 1'b1;
        wr_state = (kind_q == K_UNLOCK) ? WP_OPEN : WP_LOCKED;
        finish   = at_last;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      kind_q <= K_BAD;
      cur_q  <= '0;
      last_q <= '0;
      wp_q   <= WP_LOCKED;
    end else begin
      done_q <= busy_q && finish;
      if (accept) begin
        busy_q <= 1'b1;
        kind_q <= kind_d;
        err_q  <= 1'b0;
        irq_q  <= 1'b0;
        cur_q  <= (cmd_op == OP_UNLOCK_ALL) ? '0 : first_idx;
        last_q <= (cmd_op == OP_UNLOCK_ALL) ? TOP_IDX : last_idx;
      end else if (busy_q) begin
        if (finish) begin
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
          if (fail) err_q <= 1'b1;
        end else begin
          cur_q <= cur_q + 1'b1;
        end
      end
      if (wr_en) wp_q <= wr_state;
    end
  end

  assign cmd_ready = !busy_q;
  assign cur_idx   = cur_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign cmd_err   = err_q;
  assign irq       = irq_q;
  assign wp_status = wp_q;
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int  NUM_BLOCKS = 12,
  parameter int  DATA_W     = 16,
  localparam int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [IDX_W-1:0]  first_blk,
  output logic [IDX_W-1:0]  last_blk,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  output logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic              cmd_err,
  output logic              irq,
  output logic [2:0]        wp_status,
  input  logic [IDX_W-1:0]  q_blk,
  output logic [2:0]        q_state,
  output logic              q_writable
);
  import wp_pkg::*;

  logic [IDX_W-1:0] first_q, last_q, cur_idx;
  logic [2:0]       cur_state, wr_state;
  logic             wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (reg_we && !busy) begin
      last_q <= reg_wdata[IDX_W-1:0];
      if (!reg_sel) first_q <= reg_wdata[IDX_W-1:0];
    end
  end

  wp_range_walker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .first_idx(first_q), .last_idx(last_q),
    .cur_state(cur_state), .cur_idx(cur_idx),
    .wr_en(wr_en), .wr_state(wr_state),
    .busy(busy), .done(done), .cmd_err(cmd_err), .irq(irq),
    .wp_status(wp_status)
  );

  wp_lock_array #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(cur_idx), .wr_state(wr_state),
    .rd_idx(cur_idx), .rd_state(cur_state),
    .q_idx(q_blk), .q_state(q_state)
  );

  assign first_blk  = first_q;
  assign last_blk   = last_q;
  assign q_writable = (q_state == WP_OPEN);
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             irq,
  input logic             cmd_err,
  input logic [IDX_W-1:0] first_blk,
  input logic [IDX_W-1:0] last_blk,
  input logic [2:0]       wp_status
);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_end_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(first_blk) && $stable(last_blk)));

  assert_wp_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wp_status) == 1);

  assert_irq_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);

  assert_err_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> done);
endmodule

bind wp_guard wp_guard_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .irq(irq),
  .cmd_err(cmd_err), .first_blk(first_blk), .last_blk(last_blk),
  .wp_status(wp_status)
);

// File: tb/wp_guard_tb_top.sv
`timescale 1ns/1ps
module wp_guard_tb_top;
  localparam int NB = 12;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [IW-1:0] first_blk, last_blk, q_blk = '0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = '0;
  logic cmd_ready, busy, done, cmd_err, irq, q_writable;
  logic [2:0] wp_status, q_state;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wp_guard #(.NUM_BLOCKS(NB), .DATA_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .first_blk(first_blk), .last_blk(last_blk),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
    .busy(busy), .done(done), .cmd_err(cmd_err), .irq(irq),
    .wp_status(wp_status), .q_blk(q_blk), .q_state(q_state),
    .q_writable(q_writable)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic blk(input string tag, input int idx, input int exp);
    @(negedge clk);
    q_blk = IW'(idx);
    #1;
    chk($sformatf("%s block %0d", tag, idx), int'(q_state), exp);
  endtask

  task automatic wr_reg(input bit sel, input logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      reg_we = 1'b0;
      n++;
    end while (!done && n < 200);
  endtask

  task automatic run(input logic [7:0] op, output int n);
    issue(op);
    wait_done(n);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    chk("R1 irq", irq, 0); chk("R1 err", cmd_err, 0);
    chk("R1 wp_status", wp_status, 2);
    chk("R1 first", first_blk, 0); chk("R1 last", last_blk, 0);
    for (int i = 0; i < NB; i++) blk("R1", i, 2);
  endtask

  task automatic t_addr;
    wr_reg(1'b0, 16'h0105);
    chk("R2 first masked", first_blk, 5); chk("R2 last copied", last_blk, 5);
    wr_reg(1'b1, 16'hFF07);
    chk("R2 last only", last_blk, 7); chk("R2 first kept", first_blk, 5);
  endtask

  task automatic t_unlock_all;
    int n;
    issue(8'h27);
    chk("R3 ready low while busy", cmd_ready, 0);
    wait_done(n);
    chk("R5 cycles", n, 12);
    chk("R10 irq", irq, 1);
    for (int i = 0; i < NB; i++) blk("R5", i, 4);
    chk("R8 wp open", wp_status, 4);
    blk("R11", 3, 4); chk("R11 writable", q_writable, 1);
  endtask

  task automatic t_lock_range;
    int n;
    wr_reg(1'b0, 16'd2); wr_reg(1'b1, 16'd5);
    issue(8'h2A);
    chk("R10 irq cleared on accept", irq, 0);
    wait_done(n);
    chk("R4 lock cycles", n, 4);
    chk("R4 done busy low", busy, 0);
    blk("R4", 1, 4); blk("R4", 2, 2); blk("R4", 5, 2); blk("R4", 6, 4);
    chk("R8 wp locked", wp_status, 2);
    blk("R11", 4, 2); chk("R11 not writable", q_writable, 0);
  endtask

  task automatic t_tighten;
    int n;
    wr_reg(1'b0, 16'd0); wr_reg(1'b1, 16'd3);
    run(8'h2C, n);
    chk("R7 cycles", n, 4);
    blk("R7 skip", 0, 4); blk("R7 skip", 1, 4);
    blk("R7", 2, 1); blk("R7", 3, 1);
    chk("R8 wp tight", wp_status, 1);
  endtask

  task automatic t_stop_at_tight;
    int n;
    wr_reg(1'b0, 16'd1); wr_reg(1'b1, 16'd5);
    run(8'h23, n);
    chk("R6 unlock stops", n, 2);
    blk("R6", 2, 1); blk("R6", 4, 2); blk("R6", 5, 2);
    chk("R8 wp after unlock", wp_status, 4);
    wr_reg(1'b0, 16'd0); wr_reg(1'b1, 16'd1);
    run(8'h2A, n);
    chk("R4 lock 0..1", n, 2);
    wr_reg(1'b0, 16'd2); wr_reg(1'b1, 16'd3);
    run(8'h2A, n);
    chk("R6 lock stops", n, 1);
    blk("R6", 2, 1); blk("R6", 3, 1);
    chk("R6 wp unchanged", wp_status, 2);
    chk("R6 no err", cmd_err, 0);
  endtask

  task automatic t_range_err;
    int n;
    wr_reg(1'b0, 16'd10); wr_reg(1'b1, 16'd13);
    chk("R9 end 13 kept", last_blk, 13);
    run(8'h2A, n);
    chk("R9 cycles", n, 3);
    chk("R9 err", cmd_err, 1); chk("R10 irq", irq, 1);
    blk("R9", 10, 2); blk("R9", 11, 2);
  endtask

  task automatic t_empty;
    int n;
    wr_reg(1'b0, 16'd7); wr_reg(1'b1, 16'd5);
    run(8'h2A, n);
    chk("R9 empty cycles", n, 1);
    chk("R9 empty no err", cmd_err, 0);
    blk("R9 empty", 7, 4);
  endtask

  task automatic t_busy_write;
    int n;
    issue(8'h27);
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 16'd9;
    wait_done(n);
    chk("R5 unlock-all stops at 2", n, 3);
    chk("R3 first held", first_blk, 7); chk("R3 last held", last_blk, 5);
    blk("R5", 0, 4); blk("R5", 2, 1);
  endtask

  task automatic t_bad_op;
    int n;
    run(8'h55, n);
    chk("R10 bad op cycles", n, 1);
    chk("R10 bad op err", cmd_err, 1);
    chk("R10 bad op irq", irq, 1);
    blk("R10", 4, 2);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_addr;
    t_unlock_all;
    t_lock_range;
    t_tighten;
    t_stop_at_tight;
    t_range_err;
    t_empty;
    t_busy_write;
    t_bad_op;
    summary;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end
endmodule